// File: doc/BRIEF.md
# Page Owner Hint Forwarding Unit

Each node of a distributed shared-memory fabric has one of these units. It keeps a small table with one entry per shared page. An entry holds an ownership flag, the node's current access right (none, read or write), a probable-owner hint naming another node, and, while the node owns the page, a copy-set vector of the nodes holding read copies. Coherence messages arrive one per cycle on a network input. Local page faults arrive on a separate fault input. The unit answers, forwards or issues at most one message per cycle on a registered network output. Page contents are not carried; a page message only stands for a transfer.

When a node does not own a page, it sends a request along its hint. Any node that gets the request and is not the owner passes it on to its own hint. Each node on that path rewrites its hint from what it has just learned: the requester it forwarded for, the node that invalidated it, the node that sent it a page, or the node it gave ownership to. Each node starts as owner of the pages whose index modulo the node count equals its identity. Its hint for every other page names that page's home node.

Top module: `hint_forward_unit`

## Requirements
- R1: During and straight after reset, `tx_valid` and `err` are 0. Page p starts owned, with write access, by node p mod NODES. Every other node starts with no access to p and a hint naming that node.
- R2: A read request (kind 0) for a page this node owns produces, one cycle later, a page-copy message (kind 2) to the original requester. The requester is added to the copy-set, where bit i stands for node i, and the owner's own access drops to read.
- R3: A write request (kind 1) for an owned page produces a page-grant message (kind 3) to the requester. It carries the copy-set without the requester's bit. The node then gives up ownership and access, and its hint names the requester.
- R4: A read or write request for a page the node does not own is forwarded unchanged in kind, requester and page to the node named by the hint. The hint then names the requester.
- R5: An invalidation (kind 4) drops access to none, sets the hint to the sender, and is answered one cycle later by an acknowledgement (kind 5) to the sender for the same page.
- R6: A received page copy (kind 2) gives read access, sets the hint to the sender, and sends nothing.
- R7: A received page grant (kind 3) makes the node owner with write access. If the carried copy-set, without this node's bit, is nonzero, one invalidation is sent with that set as its target field. Destination and requester fields both name this node. Otherwise nothing is sent.
- R8: A local fault on a page the node neither owns nor can satisfy sends a read request (fault_write=0) or write request (fault_write=1) to the hint, with this node as requester.
- R9: A local read fault on a page where access is already read or write sends nothing. A local write fault on an owned page raises access to write and clears the copy-set. If the copy-set was nonzero, that invalidation is sent to it.
- R10: A request or fault that would be forwarded while the hint names this node pulses `err` for one cycle and sends nothing. Requests are never addressed to this node.
- R11: A network message takes priority over a local fault in the same cycle; the fault is dropped. An acknowledgement (kind 5) changes nothing and sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Incoming message present |
| rx_kind | input | 3 | Incoming message kind |
| rx_src | input | NW | Node that sent the message |
| rx_req | input | NW | Original requester |
| rx_page | input | PW | Page index |
| rx_copies | input | NODES | Copy-set / target vector |
| flt_valid | input | 1 | Local fault present |
| flt_write | input | 1 | Fault needs write access |
| flt_page | input | PW | Faulting page |
| tx_valid | output | 1 | Outgoing message present |
| tx_kind | output | 3 | Outgoing message kind |
| tx_dst | output | NW | Destination node |
| tx_req | output | NW | Original requester |
| tx_page | output | PW | Page index |
| tx_copies | output | NODES | Copy-set / target vector |
| err | output | 1 | Self-hint error pulse |

## Verification
The assertions check several rules on every cycle. An invalidation is always acknowledged to its sender. Page copies and acknowledgements never produce output. A request is never addressed to this node. A page grant never lists its own destination in the copy-set. An invalidation never targets an empty set or this node. An error pulse never comes with a message. Only the bench's scenarios can show that hints are actually rewritten. It does this by forcing a later fault or request on the same page and watching where the message goes. The same method shows that copy-sets accumulate across several readers and that a dropped fault really leaves no trace.

// File: rtl/hfu_pkg.sv
package hfu_pkg;
  typedef enum logic [2:0] {
    K_RD_REQ  = 3'd0,
    K_WR_REQ  = 3'd1,
    K_PAGE_RD = 3'd2,
    K_PAGE_WR = 3'd3,
    K_INVAL   = 3'd4,
    K_INV_ACK = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    A_NONE  = 2'd0,
    A_READ  = 2'd1,
    A_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/hfu_table.sv
module hfu_table
  import hfu_pkg::*;
#(
  parameter int NODES = 4,
  parameter int PAGES = 8,
  parameter int MY_ID = 0,
  localparam int NW = $clog2(NODES),
  localparam int PW = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PW-1:0]    page,
  output logic             e_owned,
  output acc_e             e_acc,
  output logic [NW-1:0]    e_hint,
  output logic [NODES-1:0] e_cset,
  input  logic             we,
  input  logic             w_owned,
  input  acc_e             w_acc,
  input  logic [NW-1:0]    w_hint,
  input  logic [NODES-1:0] w_cset
);
  logic             owned_q [PAGES];
  acc_e             acc_q   [PAGES];
  logic [NW-1:0]    hint_q  [PAGES];
  logic [NODES-1:0] cset_q  [PAGES];

  // read port is asynchronous; the single write port is shared by all events
  assign e_owned = owned_q[page];
  assign e_acc   = acc_q[page];
  assign e_hint  = hint_q[page];
  assign e_cset  = cset_q[page];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < PAGES; p++) begin
        owned_q[p] <= ((p % NODES) == MY_ID);
        acc_q[p]   <= ((p % NODES) == MY_ID) ? A_WRITE : A_NONE;
        hint_q[p]  <= NW'(p % NODES);
        cset_q[p]  <= '0;
      end
    end else if (we) begin
      owned_q[page] <= w_owned;
      acc_q[page]   <= w_acc;
      hint_q[page]  <= w_hint;
      cset_q[page]  <= w_cset;
    end
  end
endmodule

// File: rtl/hfu_engine.sv
module hfu_engine
  import hfu_pkg::*;
#(
  parameter int NODES = 4,
  parameter int PAGES = 8,
  parameter int MY_ID = 0,
  localparam int NW = $clog2(NODES),
  localparam int PW = $clog2(PAGES)
) (
  input  logic             rx_valid,
  input  logic [2:0]       rx_kind,
  input  logic [NW-1:0]    rx_src,
  input  logic [NW-1:0]    rx_req,
  input  logic [NODES-1:0] rx_copies,
  input  logic             flt_valid,
  input  logic             flt_write,
  input  logic             e_owned,
  input  acc_e             e_acc,
  input  logic [NW-1:0]    e_hint,
  input  logic [NODES-1:0] e_cset,
  output logic             we,
  output logic             w_owned,
  output acc_e             w_acc,
  output logic [NW-1:0]    w_hint,
  output logic [NODES-1:0] w_cset,
  output logic             m_valid,
  output logic [2:0]       m_kind,
  output logic [NW-1:0]    m_dst,
  output logic [NW-1:0]    m_req,
  output logic [NODES-1:0] m_copies,
  output logic             m_err
);
  localparam logic [NW-1:0]    SELF     = NW'(MY_ID);
  localparam logic [NODES-1:0] SELF_BIT = NODES'(1) << MY_ID;

  logic [NODES-1:0] req_bit;
  logic [NODES-1:0] grant_set;
  logic             hint_self;

  assign req_bit   = NODES'(1) << rx_req;
  assign grant_set = rx_copies & ~SELF_BIT;
  assign hint_self = (e_hint == SELF);

  always_comb begin
    we       = 1'b0;
    w_owned  = e_owned;
    w_acc    = e_acc;
    w_hint   = e_hint;
    w_cset   = e_cset;
    m_valid  = 1'b0;
    m_kind   = K_RD_REQ;
    m_dst    = '0;
    m_req    = '0;
    m_copies = '0;
    m_err    = 1'b0;

    if (rx_valid) begin
      unique case (rx_kind)
        K_RD_REQ, K_WR_REQ: begin
          if (e_owned && rx_kind == K_RD_REQ) begin
            m_valid = 1'b1;
            m_kind  = K_PAGE_RD;
            m_dst   = rx_req;
            m_req   = rx_req;
            we      = 1'b1;
            w_acc   = A_READ;
            w_cset  = e_cset | req_bit;
          end else if (e_owned) begin
            m_valid  = 1'b1;
            m_kind   = K_PAGE_WR;
            m_dst    = rx_req;
            m_req    = rx_req;
            m_copies = e_cset & ~req_bit;
            we       = 1'b1;
            w_owned  = 1'b0;
            w_acc    = A_NONE;
            w_hint   = rx_req;
            w_cset   = '0;
          end else if (hint_self) begin
            m_err = 1'b1;
          end else begin
            m_valid = 1'b1;
            m_kind  = rx_kind;
            m_dst   = e_hint;
            m_req   = rx_req;
            we      = 1'b1;
            w_hint  = rx_req;
          end
        end
        K_PAGE_RD: begin
          we     = 1'b1;
          w_acc  = A_READ;
          w_hint = rx_src;
        end
        K_PAGE_WR: begin
          we      = 1'b1;
          w_owned = 1'b1;
          w_acc   = A_WRITE;
          w_hint  = SELF;
          w_cset  = '0;
          if (grant_set != '0) begin
            m_valid  = 1'b1;
            m_kind   = K_INVAL;
            m_dst    = SELF;
            m_req    = SELF;
            m_copies = grant_set;
          end
        end
        K_INVAL: begin
          we      = 1'b1;
          w_acc   = A_NONE;
          w_hint  = rx_src;
          m_valid = 1'b1;
          m_kind  = K_INV_ACK;
          m_dst   = rx_src;
          m_req   = SELF;
        end
        default: ;
      endcase
    end else if (flt_valid) begin
      if (flt_write && e_owned) begin
        we     = 1'b1;
        w_acc  = A_WRITE;
        w_cset = '0;
        if (e_cset != '0) begin
          m_valid  = 1'b1;
          m_kind   = K_INVAL;
          m_dst    = SELF;
          m_req    = SELF;
          m_copies = e_cset;
        end
      end else if (!flt_write && e_acc != A_NONE) begin
        m_valid = 1'b0;
      end else if (hint_self) begin
        m_err = 1'b1;
      end else begin
        m_valid = 1'b1;
        m_kind  = flt_write ? K_WR_REQ : K_RD_REQ;
        m_dst   = e_hint;
        m_req   = SELF;
      end
    end
  end
endmodule

// File: rtl/hint_forward_unit.sv
module hint_forward_unit
  import hfu_pkg::*;
#(
  parameter int NODES = 4,
  parameter int PAGES = 8,
  parameter int MY_ID = 1,
  localparam int NW = $clog2(NODES),
  localparam int PW = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [2:0]       rx_kind,
  input  logic [NW-1:0]    rx_src,
  input  logic [NW-1:0]    rx_req,
  input  logic [PW-1:0]    rx_page,
  input  logic [NODES-1:0] rx_copies,
  input  logic             flt_valid,
  input  logic             flt_write,
  input  logic [PW-1:0]    flt_page,
  output logic             tx_valid,
  output logic [2:0]       tx_kind,
  output logic [NW-1:0]    tx_dst,
  output logic [NW-1:0]    tx_req,
  output logic [PW-1:0]    tx_page,
  output logic [NODES-1:0] tx_copies,
  output logic             err
);
  logic [PW-1:0]    cur_page;
  logic             e_owned, we, w_owned;
  acc_e             e_acc, w_acc;
  logic [NW-1:0]    e_hint, w_hint;
  logic [NODES-1:0] e_cset, w_cset;
  logic             m_valid, m_err;
  logic [2:0]       m_kind;
  logic [NW-1:0]    m_dst, m_req;
  logic [NODES-1:0] m_copies;

  assign cur_page = rx_valid ? rx_page : flt_page;

  hfu_table #(.NODES(NODES), .PAGES(PAGES), .MY_ID(MY_ID)) u_table (
    .clk(clk), .rst(rst), .page(cur_page),
    .e_owned(e_owned), .e_acc(e_acc), .e_hint(e_hint), .e_cset(e_cset),
    .we(we), .w_owned(w_owned), .w_acc(w_acc), .w_hint(w_hint), .w_cset(w_cset)
  );

  hfu_engine #(.NODES(NODES), .PAGES(PAGES), .MY_ID(MY_ID)) u_engine (
    .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_src(rx_src), .rx_req(rx_req),
    .rx_copies(rx_copies), .flt_valid(flt_valid), .flt_write(flt_write),
    .e_owned(e_owned), .e_acc(e_acc), .e_hint(e_hint), .e_cset(e_cset),
    .we(we), .w_owned(w_owned), .w_acc(w_acc), .w_hint(w_hint), .w_cset(w_cset),
    .m_valid(m_valid), .m_kind(m_kind), .m_dst(m_dst), .m_req(m_req),
    .m_copies(m_copies), .m_err(m_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid  <= 1'b0;
      tx_kind   <= '0;
      tx_dst    <= '0;
      tx_req    <= '0;
      tx_page   <= '0;
      tx_copies <= '0;
      err       <= 1'b0;
    end else begin
      tx_valid  <= m_valid;
      tx_kind   <= m_kind;
      tx_dst    <= m_dst;
      tx_req    <= m_req;
      tx_page   <= cur_page;
      tx_copies <= m_copies;
      err       <= m_err;
    end
  end
endmodule

// File: rtl/hint_forward_unit_chk.sv
module hint_forward_unit_chk #(
  parameter int NODES = 4,
  parameter int PAGES = 8,
  parameter int MY_ID = 1,
  localparam int NW = $clog2(NODES),
  localparam int PW = $clog2(PAGES)
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic [2:0]       rx_kind,
  input logic [NW-1:0]    rx_src,
  input logic [NW-1:0]    rx_req,
  input logic [PW-1:0]    rx_page,
  input logic [NODES-1:0] rx_copies,
  input logic             flt_valid,
  input logic             flt_write,
  input logic [PW-1:0]    flt_page,
  input logic             tx_valid,
  input logic [2:0]       tx_kind,
  input logic [NW-1:0]    tx_dst,
  input logic [NW-1:0]    tx_req,
  input logic [PW-1:0]    tx_page,
  input logic [NODES-1:0] tx_copies,
  input logic             err
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !tx_valid && !err);

  p_grant_excl_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_kind == 3'd3) |-> !tx_copies[tx_dst]);

  p_inv_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_kind == 3'd4) |=>
      (tx_valid && tx_kind == 3'd5 && tx_dst == $past(rx_src) && tx_page == $past(rx_page)));

  p_copy_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_kind == 3'd2) |=> (!tx_valid && !err));

  p_inval_targets_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_kind == 3'd4) |-> (tx_copies != '0 && !tx_copies[MY_ID]));

  p_no_self_req_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && (tx_kind == 3'd0 || tx_kind == 3'd1)) |-> tx_dst != NW'(MY_ID));

  p_err_alone_r10: assert property (@(posedge clk) disable iff (rst)
    err |-> !tx_valid);

  p_ack_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_kind == 3'd5) |=> (!tx_valid && !err));
endmodule

bind hint_forward_unit hint_forward_unit_chk #(.NODES(NODES), .PAGES(PAGES), .MY_ID(MY_ID)) u_chk (.*);

// File: tb/hint_forward_unit_test.sv
module hint_forward_unit_test;
  localparam int NODES = 4;
  localparam int PAGES = 8;
  localparam int MY_ID = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [2:0] rx_kind = '0;
  logic [1:0] rx_src = '0, rx_req = '0;
  logic [2:0] rx_page = '0;
  logic [3:0] rx_copies = '0;
  logic       flt_valid = 1'b0, flt_write = 1'b0;
  logic [2:0] flt_page = '0;
  logic       tx_valid, err;
  logic [2:0] tx_kind, tx_page;
  logic [1:0] tx_dst, tx_req;
  logic [3:0] tx_copies;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic v; logic [2:0] k; logic [1:0] d; logic [1:0] q;
    logic [2:0] pg; logic [3:0] c; logic e; string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  hint_forward_unit #(.NODES(NODES), .PAGES(PAGES), .MY_ID(MY_ID)) uut (.*);

  task automatic expect_out(input logic v, input logic [2:0] k, input logic [1:0] d,
                            input logic [1:0] q, input logic [2:0] pg,
                            input logic [3:0] c, input logic e, input string tag);
    exp_t x;
    x.v = v; x.k = k; x.d = d; x.q = q; x.pg = pg; x.c = c; x.e = e; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic net(input logic [2:0] k, input logic [1:0] s, input logic [1:0] q,
                     input logic [2:0] pg, input logic [3:0] c);
    @(negedge clk);
    rx_valid = 1'b1; rx_kind = k; rx_src = s; rx_req = q; rx_page = pg; rx_copies = c;
    flt_valid = 1'b0;
  endtask

  task automatic fault(input logic w, input logic [2:0] pg);
    @(negedge clk);
    rx_valid = 1'b0; flt_valid = 1'b1; flt_write = w; flt_page = pg;
  endtask

  task automatic idle();
    @(negedge clk);
    rx_valid = 1'b0; flt_valid = 1'b0;
    expect_out(0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  // monitor: one scoreboard item per cycle, compared after the output register updates
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t x;
        logic ok;
        x = sb.pop_front();
        ok = (tx_valid === x.v) && (err === x.e);
        if (x.v)
          ok = ok && tx_kind === x.k && tx_dst === x.d && tx_req === x.q &&
               tx_page === x.pg && tx_copies === x.c;
        checks++;
        if (!ok) begin
          fails++;
          $display("FAIL %s: got v=%0b k=%0d d=%0d q=%0d pg=%0d c=%b e=%0b exp v=%0b k=%0d d=%0d q=%0d pg=%0d c=%b e=%0b",
                   x.tag, tx_valid, tx_kind, tx_dst, tx_req, tx_page, tx_copies, err,
                   x.v, x.k, x.d, x.q, x.pg, x.c, x.e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (tx_valid !== 1'b0 || err !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got v=%0b e=%0b exp v=0 e=0", tx_valid, err);
    end
    @(negedge clk); rst = 1'b0;

    // node 1 owns pages 1 and 5 from reset
    net(0, 2, 2, 1, 4'b0000); expect_out(1, 2, 2, 2, 1, 4'b0000, 0, "R1 R2 read copy to 2");
    net(0, 3, 3, 1, 4'b0000); expect_out(1, 2, 3, 3, 1, 4'b0000, 0, "R2 read copy to 3");
    fault(1, 1);              expect_out(1, 4, 1, 1, 1, 4'b1100, 0, "R9 upgrade invalidates 2,3");
    fault(0, 1);              expect_out(0, 0, 0, 0, 0, 0, 0, "R9 read fault on readable page");
    net(0, 0, 0, 1, 4'b0000); expect_out(1, 2, 0, 0, 1, 4'b0000, 0, "R2 read copy to 0");
    net(1, 2, 2, 1, 4'b0000); expect_out(1, 3, 2, 2, 1, 4'b0001, 0, "R3 grant with copy-set");
    net(0, 3, 3, 1, 4'b0000); expect_out(1, 0, 2, 3, 1, 4'b0000, 0, "R3 R4 forward to new owner 2");
    fault(0, 1);              expect_out(1, 0, 3, 1, 1, 4'b0000, 0, "R4 R8 hint now requester 3");
    net(0, 0, 0, 2, 4'b0000); expect_out(1, 0, 2, 0, 2, 4'b0000, 0, "R1 R4 forward to home 2");
    fault(1, 2);              expect_out(1, 1, 0, 1, 2, 4'b0000, 0, "R8 write request to hint 0");
    net(4, 3, 3, 6, 4'b0010); expect_out(1, 5, 3, 1, 6, 4'b0000, 0, "R5 ack to invalidator");
    fault(0, 6);              expect_out(1, 0, 3, 1, 6, 4'b0000, 0, "R5 hint is invalidator");
    net(2, 2, 1, 7, 4'b0000); expect_out(0, 0, 0, 0, 0, 0, 0, "R6 copy silent");
    fault(1, 7);              expect_out(1, 1, 2, 1, 7, 4'b0000, 0, "R6 hint is copy sender");
    net(3, 0, 1, 4, 4'b1100); expect_out(1, 4, 1, 1, 4, 4'b1100, 0, "R7 grant invalidates copies");
    net(0, 2, 2, 4, 4'b0000); expect_out(1, 2, 2, 2, 4, 4'b0000, 0, "R7 now owner serves read");
    net(3, 0, 1, 0, 4'b0000); expect_out(0, 0, 0, 0, 0, 0, 0, "R7 empty grant silent");
    fault(1, 0);              expect_out(0, 0, 0, 0, 0, 0, 0, "R9 owned write no copies");
    net(1, 0, 1, 3, 4'b0000); expect_out(1, 1, 3, 1, 3, 4'b0000, 0, "R4 forward own loop request");
    fault(0, 3);              expect_out(0, 0, 0, 0, 0, 0, 1, "R10 fault with self hint");
    net(0, 2, 2, 3, 4'b0000); expect_out(0, 0, 0, 0, 0, 0, 1, "R10 request with self hint");
    @(negedge clk);
    rx_valid = 1'b1; rx_kind = 5; rx_src = 2; rx_req = 2; rx_page = 5; rx_copies = 0;
    flt_valid = 1'b1; flt_write = 1'b1; flt_page = 2;
    expect_out(0, 0, 0, 0, 0, 0, 0, "R11 ack ignored, fault dropped");
    @(negedge clk);
    rx_valid = 1'b1; rx_kind = 0; rx_src = 2; rx_req = 2; rx_page = 5; rx_copies = 0;
    flt_valid = 1'b1; flt_write = 1'b0; flt_page = 6;
    expect_out(1, 2, 2, 2, 5, 4'b0000, 0, "R11 network wins over fault");
    idle();
    idle();
    wait (sb.size() == 0);
    @(posedge clk); #3;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule